// File: doc/BRIEF.md
# Associative Page Table Lookup

This block is a small content-addressed translation table. It keeps one word per physical memory block, and each word pairs a virtual page number with the block number that holds that page. There is no slot for every virtual page. A lookup presents a page number on the search argument. Every stored word is compared against it in the same cycle, and a mask register selects which argument bits take part in the compare. The result appears on registered outputs one clock after the request. It is either the block number of the matching word or a page-fault indication.

The words are loaded through a write port that names a word index and gives its page, block and valid bit. The block does not choose which word to replace. The surrounding logic picks the index and drives it on the write port. If more than one valid word matches the masked argument, the word with the lowest index supplies the block number and a multi-hit flag is raised. A write and a search requested in the same cycle are resolved in favour of the write, and that search is dropped.

Top module: `apt_lookup`

## Requirements
- R1: After reset every word is invalid, the key mask is all ones (full page field compared), and rsp_valid, rsp_fault, rsp_multi and rsp_block are all 0.
- R2: With wr_en high, the word at wr_idx takes wr_page, wr_block and wr_valid at the clock edge, and a later search sees the new contents.
- R3: A cycle with srch_req high and wr_en low produces rsp_valid high for exactly the following cycle. On a hit, rsp_block carries the block field of the matching word and rsp_fault is 0.
- R4: When no valid word matches the masked argument, the response has rsp_fault = 1, rsp_block = 0 and rsp_multi = 0.
- R5: A word whose valid bit is 0 never matches, whatever its page field holds.
- R6: Only argument bits whose key mask bit is 1 are compared. key_wr loads key_in into the mask at the clock edge, and the mask changes at no other time. A mask of all zeros makes every valid word match.
- R7: When two or more valid words match, rsp_block comes from the lowest-index matching word and rsp_multi is 1. When exactly one word matches, rsp_multi is 0.
- R8: If wr_en and srch_req are both high in one cycle, the write is performed, the search is discarded, and rsp_valid stays 0 in the next cycle.
- R9: In cycles where rsp_valid is 0, rsp_block, rsp_fault and rsp_multi keep their previous values.
- R10: A search issued in the same cycle as a key_wr uses the mask value held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| key_wr | input | 1 | Load key_in into the compare mask |
| key_in | input | PW | New compare mask, one bit per page bit |
| wr_en | input | 1 | Write one table word |
| wr_idx | input | IW | Index of the word to write |
| wr_page | input | PW | Page number to store |
| wr_block | input | BW | Block number to store |
| wr_valid | input | 1 | Valid bit to store |
| srch_req | input | 1 | Search request strobe |
| srch_arg | input | PW | Page number to look up |
| rsp_valid | output | 1 | One-cycle pulse marking a fresh search result |
| rsp_block | output | BW | Block number of the selected match, 0 on a fault |
| rsp_fault | output | 1 | No valid word matched the search |
| rsp_multi | output | 1 | More than one valid word matched |

## Verification
The checker watches several properties on every clock cycle. It confirms that rsp_valid pulses exactly one cycle after each accepted search and at no other time, which covers the drop of a search that collides with a write. It confirms that a fault never carries a block number or a multi-hit flag, that the result fields hold steady between responses, and that the key mask moves only after a key write. The values themselves need the bench's scenarios to show them. These include which block number comes back, how the lowest-index rule settles a multi-hit, how invalid words and masked-out bits are ignored, and whether a same-cycle key write uses the old mask. The bench compares each of these against the table contents it has written.

// File: rtl/apt_pkg.sv
package apt_pkg;
  localparam int unsigned APT_WORDS_DEF = 4;
  localparam int unsigned APT_PAGE_W_DEF = 3;
  localparam int unsigned APT_BLOCK_W_DEF = 2;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_ONE   = 2'd1,
    SEL_MANY  = 2'd2
  } sel_kind_e;
endpackage

// File: rtl/apt_entries.sv
module apt_entries #(
  parameter int unsigned M  = apt_pkg::APT_WORDS_DEF,
  parameter int unsigned PW = apt_pkg::APT_PAGE_W_DEF,
  parameter int unsigned BW = apt_pkg::APT_BLOCK_W_DEF,
  parameter int unsigned IW = (M > 1) ? $clog2(M) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [PW-1:0]   wr_page,
  input  logic [BW-1:0]   wr_block,
  input  logic            wr_valid,
  output logic [M*PW-1:0] page_flat,
  output logic [M*BW-1:0] block_flat,
  output logic [M-1:0]    valid_vec
);
  for (genvar g = 0; g < M; g++) begin : g_word
    logic          sel;
    logic [PW-1:0] page_q, page_d;
    logic [BW-1:0] block_q, block_d;
    logic          valid_q, valid_d;

    always_comb begin
      sel     = wr_en && (wr_idx == IW'(g));
      page_d  = page_q;
      block_d = block_q;
      valid_d = valid_q;
      if (sel) begin
        page_d  = wr_page;
        block_d = wr_block;
        valid_d = wr_valid;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        page_q  <= '0;
        block_q <= '0;
        valid_q <= 1'b0;
      end else if (sel) begin
        page_q  <= page_d;
        block_q <= block_d;
        valid_q <= valid_d;
      end
    end

    assign page_flat[g*PW +: PW]  = page_q;
    assign block_flat[g*BW +: BW] = block_q;
    assign valid_vec[g]           = valid_q;
  end
endmodule

// File: rtl/apt_compare.sv
module apt_compare #(
  parameter int unsigned M  = apt_pkg::APT_WORDS_DEF,
  parameter int unsigned PW = apt_pkg::APT_PAGE_W_DEF
) (
  input  logic [M*PW-1:0] page_flat,
  input  logic [M-1:0]    valid_vec,
  input  logic [PW-1:0]   arg,
  input  logic [PW-1:0]   key,
  output logic [M-1:0]    hit_vec
);
  for (genvar g = 0; g < M; g++) begin : g_cmp
    logic [PW-1:0] diff;
    always_comb begin
      diff       = (page_flat[g*PW +: PW] ^ arg) & key;
      hit_vec[g] = valid_vec[g] && (diff == '0);
    end
  end
endmodule

// File: rtl/apt_select.sv
module apt_select #(
  parameter int unsigned M  = apt_pkg::APT_WORDS_DEF,
  parameter int unsigned BW = apt_pkg::APT_BLOCK_W_DEF,
  parameter int unsigned CW = $clog2(M + 1)
) (
  input  logic [M-1:0]      hit_vec,
  input  logic [M*BW-1:0]   block_flat,
  output apt_pkg::sel_kind_e kind,
  output logic [BW-1:0]     block
);
  logic [CW-1:0] hits;

  always_comb begin
    hits  = '0;
    block = '0;
    for (int i = M - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        block = block_flat[i*BW +: BW];
        hits  = hits + CW'(1);
      end
    end
    if (hits == '0)
      kind = apt_pkg::SEL_NONE;
    else if (hits == CW'(1))
      kind = apt_pkg::SEL_ONE;
    else
      kind = apt_pkg::SEL_MANY;
  end
endmodule

// File: rtl/apt_lookup.sv
module apt_lookup #(
  parameter int unsigned M  = apt_pkg::APT_WORDS_DEF,
  parameter int unsigned PW = apt_pkg::APT_PAGE_W_DEF,
  parameter int unsigned BW = apt_pkg::APT_BLOCK_W_DEF,
  parameter int unsigned IW = (M > 1) ? $clog2(M) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_wr,
  input  logic [PW-1:0] key_in,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [PW-1:0] wr_page,
  input  logic [BW-1:0] wr_block,
  input  logic          wr_valid,
  input  logic          srch_req,
  input  logic [PW-1:0] srch_arg,
  output logic          rsp_valid,
  output logic [BW-1:0] rsp_block,
  output logic          rsp_fault,
  output logic          rsp_multi
);
  import apt_pkg::*;

  // reset synchronizer: asserts at once, releases on the clock
  logic rst_s1, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  logic [M*PW-1:0] page_flat;
  logic [M*BW-1:0] block_flat;
  logic [M-1:0]    valid_vec;
  logic [M-1:0]    hit_vec;
  sel_kind_e       kind;
  logic [BW-1:0]   sel_block;

  apt_entries #(.M(M), .PW(PW), .BW(BW), .IW(IW)) u_entries (
    .clk(clk), .rst_n(rst_q),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_page(wr_page),
    .wr_block(wr_block), .wr_valid(wr_valid),
    .page_flat(page_flat), .block_flat(block_flat), .valid_vec(valid_vec)
  );

  // key mask register
  logic [PW-1:0] key_q, key_d;
  always_comb begin
    key_d = key_q;
    if (key_wr) key_d = key_in;
  end
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)      key_q <= '1;
    else if (key_wr) key_q <= key_d;
  end

  apt_compare #(.M(M), .PW(PW)) u_cmp (
    .page_flat(page_flat), .valid_vec(valid_vec),
    .arg(srch_arg), .key(key_q), .hit_vec(hit_vec)
  );

  apt_select #(.M(M), .BW(BW)) u_sel (
    .hit_vec(hit_vec), .block_flat(block_flat),
    .kind(kind), .block(sel_block)
  );

  // response registers
  logic          accept;
  logic          vld_d;
  logic [BW-1:0] blk_d;
  logic          flt_d, mul_d;

  always_comb begin
    accept = srch_req && !wr_en;
    vld_d  = accept;
    blk_d  = rsp_block;
    flt_d  = rsp_fault;
    mul_d  = rsp_multi;
    if (accept) begin
      blk_d = sel_block;
      flt_d = (kind == SEL_NONE);
      mul_d = (kind == SEL_MANY);
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) rsp_valid <= 1'b0;
    else        rsp_valid <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rsp_block <= '0;
      rsp_fault <= 1'b0;
      rsp_multi <= 1'b0;
    end else if (accept) begin
      rsp_block <= blk_d;
      rsp_fault <= flt_d;
      rsp_multi <= mul_d;
    end
  end
endmodule

// File: rtl/apt_lookup_chk.sv
module apt_lookup_chk #(
  parameter int unsigned PW = 3,
  parameter int unsigned BW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          srch_req,
  input logic          wr_en,
  input logic          key_wr,
  input logic [PW-1:0] key_q,
  input logic          rsp_valid,
  input logic [BW-1:0] rsp_block,
  input logic          rsp_fault,
  input logic          rsp_multi
);
  assert_resp_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_req && !wr_en) |=> rsp_valid);

  assert_no_spurious_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(srch_req && !wr_en) |=> !rsp_valid);

  assert_fault_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_block == '0 && !rsp_multi));

  assert_multi_not_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_multi |-> !rsp_fault);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> ($stable(rsp_block) && $stable(rsp_fault) && $stable(rsp_multi)));

  assert_key_only_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(key_wr) |-> $stable(key_q));

  assert_key_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (key_q == '1));
endmodule

bind apt_lookup apt_lookup_chk #(.PW(PW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_q), .srch_req(srch_req), .wr_en(wr_en),
  .key_wr(key_wr), .key_q(key_q), .rsp_valid(rsp_valid),
  .rsp_block(rsp_block), .rsp_fault(rsp_fault), .rsp_multi(rsp_multi)
);

// File: tb/tb_apt_lookup.sv
module tb_apt_lookup;
  localparam int M = 4, PW = 3, BW = 2, IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key_wr = 1'b0;
  logic [PW-1:0] key_in = '0;
  logic wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [PW-1:0] wr_page = '0;
  logic [BW-1:0] wr_block = '0;
  logic wr_valid = 1'b0;
  logic srch_req = 1'b0;
  logic [PW-1:0] srch_arg = '0;
  logic rsp_valid, rsp_fault, rsp_multi;
  logic [BW-1:0] rsp_block;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  apt_lookup #(.M(M), .PW(PW), .BW(BW)) dut (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_in(key_in),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_page(wr_page), .wr_block(wr_block),
    .wr_valid(wr_valid), .srch_req(srch_req), .srch_arg(srch_arg),
    .rsp_valid(rsp_valid), .rsp_block(rsp_block),
    .rsp_fault(rsp_fault), .rsp_multi(rsp_multi)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // response packed as {valid, fault, multi, block}
  function automatic int rsp();
    return {rsp_valid, rsp_fault, rsp_multi, rsp_block};
  endfunction

  task automatic check_rsp(input string req, input bit f, input bit mh, input int b);
    int e = {1'b1, f, mh, b[BW-1:0]};
    chk(rsp() == e, req, rsp(), e);
  endtask

  task automatic do_write(input int idx, input int pg, input int bl, input bit v);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_page = PW'(pg); wr_block = BW'(bl); wr_valid = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_key(input int k);
    @(negedge clk);
    key_wr = 1'b1; key_in = PW'(k);
    @(negedge clk);
    key_wr = 1'b0;
  endtask

  task automatic do_search(input int a);
    @(negedge clk);
    srch_req = 1'b1; srch_arg = PW'(a);
    @(negedge clk);
    srch_req = 1'b0;
  endtask

  // vector: {arg[2:0], fault, multi, block[1:0]}
  localparam logic [6:0] VEC [6] = '{
    {3'd5, 1'b0, 1'b0, 2'd2},
    {3'd3, 1'b0, 1'b0, 2'd1},
    {3'd6, 1'b0, 1'b0, 2'd3},
    {3'd1, 1'b1, 1'b0, 2'd0},
    {3'd0, 1'b1, 1'b0, 2'd0},
    {3'd7, 1'b1, 1'b0, 2'd0}
  };

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #40000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state of outputs
    chk(rsp() == 0, "R1 outputs after reset", rsp(), 0);
    // R1: all words invalid after reset
    do_search(0);
    check_rsp("R1 empty table faults", 1, 0, 0);
    // R1 / R2: key mask all ones -> page 4 must not hit stored page 5
    do_write(0, 5, 2, 1);
    do_search(4);
    check_rsp("R1 default key full compare", 1, 0, 0);
    do_write(1, 3, 1, 1);
    do_write(2, 6, 3, 1);
    do_write(3, 1, 0, 0);   // R5: invalid word holding page 1
    // table-driven lookups: R2, R3, R4, R5
    for (int i = 0; i < 6; i++) begin
      do_search(int'(VEC[i][6:4]));
      check_rsp($sformatf("R3/R4/R5 vector %0d", i), VEC[i][3], VEC[i][2], int'(VEC[i][1:0]));
    end
    // R9: idle cycle keeps last result fields, valid low
    @(negedge clk);
    chk(rsp() == {1'b0, 1'b1, 1'b0, 2'd0}, "R9 hold when idle", rsp(), {1'b0, 1'b1, 1'b0, 2'd0});
    // R6: ignore bit0
    do_key(3'b110);
    do_search(7);
    check_rsp("R6 masked bit0 hit", 0, 0, 3);
    do_search(2);
    check_rsp("R6 masked arg 2", 0, 0, 1);
    // R7: only bit2 compared -> words 0 and 2 match
    do_key(3'b100);
    do_search(4);
    check_rsp("R7 lowest index wins", 0, 1, 2);
    // R6/R7: zero mask -> every valid word matches
    do_key(3'b000);
    do_search(5);
    check_rsp("R6 zero mask all match", 0, 1, 2);
    do_key(3'b111);
    // R8: write and search together
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 2'd3; wr_page = 3'd1; wr_block = 2'd0; wr_valid = 1'b1;
    srch_req = 1'b1; srch_arg = 3'd5;
    @(negedge clk);
    wr_en = 1'b0; srch_req = 1'b0;
    chk(rsp_valid == 1'b0, "R8 search dropped on write", int'(rsp_valid), 0);
    do_search(1);
    check_rsp("R8 write applied", 0, 0, 0);
    // R2: overwrite word 0 with a new mapping
    do_write(0, 4, 1, 1);
    do_search(5);
    check_rsp("R2 old mapping gone", 1, 0, 0);
    do_search(4);
    check_rsp("R2 new mapping", 0, 0, 1);
    // R10: key write and search in the same cycle
    @(negedge clk);
    key_wr = 1'b1; key_in = 3'b000; srch_req = 1'b1; srch_arg = 3'd0;
    @(negedge clk);
    key_wr = 1'b0; srch_req = 1'b0;
    check_rsp("R10 old key used", 1, 0, 0);
    do_search(0);
    check_rsp("R10 new key afterwards", 0, 1, 1);
    // R5: invalidate word 0; zero mask now picks word 1
    do_write(0, 4, 1, 0);
    do_search(0);
    check_rsp("R5 invalid word skipped", 0, 1, 1);
    finish_up();
  end
endmodule